// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves one byte at a time over a single data line and drives the shift clock itself. The CPU clock is divided into machine cycles of six states, S1 to S6. Each state lasts one clock, so one bit moves every six clocks. Every event in the port is tied to a fixed state within the machine cycle. Bits go out and come in least significant bit first.

Writing a byte to the buffer starts a transmit. The port drives the data line for eight machine cycles and then raises the transmit flag. Setting receive-enable while the receive flag is clear starts a receive. The port pulses the shift clock for eight machine cycles and samples the line once per cycle. It then loads the read buffer and raises the receive flag. Completion is not detected by a bit counter. It is detected by a marker bit that walks through each shift register: a one above the transmit data, and a zero at the bottom of the receive register.

Each engine has named states and transitions. Transmit: TX_IDLE, then a write goes to TX_WAIT (rest of the write's cycle). At S6 it goes to TX_GAP (one full idle cycle). At S6 it goes to TX_SEND. When the marker reaches the end at S6 it returns to TX_IDLE. If the write lands in S6, TX_IDLE goes straight to TX_GAP. Receive: RX_IDLE, then the start condition goes to RX_WAIT. At S6 it goes to RX_ARM. At S6 it loads the marker pattern and goes to RX_RECV. When the marker reaches the top at S6 it returns to RX_IDLE. If the start condition lands in S6, RX_IDLE goes straight to RX_ARM.

Top module: `ssp_port`

## Requirements
- R1: After reset the first state is S1 and states advance S1..S6 one per clock and wrap. Reset values: sclk=1, sd_oe=0, ti=0, ri=0, rd_data=0.
- R2: sclk is 0 in states S3, S4 and S5 of every machine cycle in which a transmit or receive is shifting. It is 1 at all other times.
- R3: Number the machine cycle containing the accepted write as cycle 0. sd_oe is 1 exactly during cycles 2 to 9, and 0 otherwise.
- R4: During transmit cycle 2+n (n = 0..7), sd_out carries bit n of the written byte.
- R5: ti becomes 1 in S1 of cycle 10 after the write, and stays 1 until ti_clr.
- R6: Number the cycle containing the first state in which ren=1 and ri=0 (with the port idle) as cycle 0. Receive shifting (sclk pulses) occurs during cycles 2 to 9, and sd_oe stays 0.
- R7: In receive cycle 2+n, the value of sd_in at the S5 clock edge becomes bit n of the received byte. Values at other states have no effect.
- R8: ri becomes 1 in S1 of cycle 10 and rd_data then holds the received byte. ri stays 1 until ri_clr, and no receive starts while ri=1.
- R9: With ren=0 no receive starts: sclk stays 1 and ri stays 0.
- R10: A buffer write while a transmit or receive is in progress is ignored. A write in the same clock as a receive start condition takes priority.
- R11: ti_clr and ri_clr clear their flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one state per clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe, starts a transmit |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| ren | input | 1 | Receive enable |
| ti_clr | input | 1 | Clears the transmit-done flag |
| ri_clr | input | 1 | Clears the receive-done flag |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| sd_in | input | 1 | Data line input |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock |

## Verification
Transfers are started in every one of the six states, both through directed bytes and random bytes. This separates an engine that locks to machine-cycle boundaries from one that counts clocks from the trigger; a write or start landing in S6 is the sharpest case. On receive, the bench drives the true bit only in state S5 and its inverse in every other state, so any sampling at the wrong phase shows up as a corrupted byte. Writes issued during a busy transfer, an idle period with ren low, and a period with ri held set show that the ignore and blocking rules leave the line and clock untouched.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int PH_COUNT = 6;
    localparam int PH_W     = $clog2(PH_COUNT);

    typedef enum logic [PH_W-1:0] {
        PH_S1 = 3'd0,
        PH_S2 = 3'd1,
        PH_S3 = 3'd2,
        PH_S4 = 3'd3,
        PH_S5 = 3'd4,
        PH_S6 = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT,
        TX_GAP,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT,
        RX_ARM,
        RX_RECV
    } rx_state_e;

    // Shift clock is pulled low in the middle three states of a cycle.
    function automatic logic clk_low_phase(phase_e p);
        return (p == PH_S3) || (p == PH_S4) || (p == PH_S5);
    endfunction

endpackage

// File: rtl/ssp_phase.sv
module ssp_phase
    import ssp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e ph,
    output logic   at_s5,
    output logic   at_s6
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_S1;
        end else if (ph == PH_S6) begin
            ph <= PH_S1;
        end else begin
            ph <= phase_e'(ph + 3'd1);
        end
    end

    always_comb begin
        at_s5 = (ph == PH_S5);
        at_s6 = (ph == PH_S6);
    end

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_s6,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              flag_clr,
    output logic              send,
    output logic              busy,
    output logic              bit_out,
    output logic              done_flag
);

    localparam int SR_W = DATA_W + 1;

    tx_state_e        state_q, state_d;
    logic [SR_W-1:0]  sr_q;
    logic             marker_last;

    // Only the marker left above the output bit: this is the final shift.
    assign marker_last = (sr_q[SR_W-1:2] == '0) && sr_q[1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load)  state_d = at_s6 ? TX_GAP : TX_WAIT;
            TX_WAIT: if (at_s6) state_d = TX_GAP;
            TX_GAP:  if (at_s6) state_d = TX_SEND;
            TX_SEND: if (at_s6 && marker_last) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q      <= '0;
            done_flag <= 1'b0;
        end else begin
            if (state_q == TX_IDLE && load) begin
                sr_q <= {1'b1, load_data};
            end else if (state_q == TX_SEND && at_s6) begin
                sr_q <= {1'b0, sr_q[SR_W-1:1]};
            end
            if (state_q == TX_SEND && at_s6 && marker_last) begin
                done_flag <= 1'b1;
            end else if (flag_clr) begin
                done_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        send    = (state_q == TX_SEND);
        busy    = (state_q != TX_IDLE);
        bit_out = sr_q[0];
    end

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_s5,
    input  logic              at_s6,
    input  logic              start_ok,
    input  logic              flag_clr,
    input  logic              line_in,
    output logic              recv,
    output logic              busy,
    output logic              done_flag,
    output logic [DATA_W-1:0] rx_buf
);

    rx_state_e         state_q, state_d;
    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] sr_shifted;
    logic [DATA_W-1:0] sr_reversed;
    logic              sample_q;
    logic              start;
    logic              finish;

    assign start      = start_ok && !done_flag;
    assign sr_shifted = {sr_q[DATA_W-2:0], sample_q};
    // The zero loaded at the bottom has climbed to the top: last shift.
    assign finish     = (state_q == RX_RECV) && at_s6 && !sr_q[DATA_W-1];

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            sr_reversed[i] = sr_shifted[DATA_W-1-i];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (start) state_d = at_s6 ? RX_ARM : RX_WAIT;
            RX_WAIT: if (at_s6) state_d = RX_ARM;
            RX_ARM:  if (at_s6) state_d = RX_RECV;
            RX_RECV: if (finish) state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q      <= '0;
            sample_q  <= 1'b0;
            rx_buf    <= '0;
            done_flag <= 1'b0;
        end else begin
            if (state_q == RX_RECV && at_s5) begin
                sample_q <= line_in;
            end
            if (state_q == RX_ARM && at_s6) begin
                sr_q <= {{(DATA_W-1){1'b1}}, 1'b0};
            end else if (state_q == RX_RECV && at_s6) begin
                sr_q <= sr_shifted;
            end
            if (finish) begin
                rx_buf    <= sr_reversed;
                done_flag <= 1'b1;
            end else if (flag_clr) begin
                done_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        recv = (state_q == RX_RECV);
        busy = (state_q != RX_IDLE);
    end

endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ren,
    input  logic              ti_clr,
    input  logic              ri_clr,
    output logic              ti,
    output logic              ri,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              sclk
);

    phase_e ph_w;
    logic   at_s5, at_s6;
    logic   send_w, recv_w;
    logic   tx_busy, rx_busy;
    logic   tx_bit;
    logic   wr_accept;
    logic   rx_start_ok;

    // Writes only land on an idle port; a write beats a receive start.
    assign wr_accept   = wr_en && !tx_busy && !rx_busy;
    assign rx_start_ok = ren && !tx_busy && !wr_en;

    ssp_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph_w),
        .at_s5 (at_s5),
        .at_s6 (at_s6)
    );

    ssp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_s6     (at_s6),
        .load      (wr_accept),
        .load_data (wr_data),
        .flag_clr  (ti_clr),
        .send      (send_w),
        .busy      (tx_busy),
        .bit_out   (tx_bit),
        .done_flag (ti)
    );

    ssp_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_s5     (at_s5),
        .at_s6     (at_s6),
        .start_ok  (rx_start_ok),
        .flag_clr  (ri_clr),
        .line_in   (sd_in),
        .recv      (recv_w),
        .busy      (rx_busy),
        .done_flag (ri),
        .rx_buf    (rd_data)
    );

    always_comb begin
        sd_oe  = send_w;
        sd_out = send_w & tx_bit;
        sclk   = !((send_w || recv_w) && clk_low_phase(ph_w));
    end

endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ph,
    input logic       send,
    input logic       recv,
    input logic       ti,
    input logic       ri,
    input logic       ti_clr,
    input logic       ri_clr,
    input logic       sclk
);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 3'd5) |=> (ph == 3'd0)); // R1

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!send && !recv) |-> sclk); // R2

    AST_SEND_AT_S1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send) |-> (ph == 3'd0)); // R3

    AST_SEND_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(send) |-> ti); // R5

    AST_TI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ti && !ti_clr) |=> ti); // R5

    AST_RI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !ri_clr) |=> ri); // R8

    AST_NO_RX_WITH_RI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recv) |-> !ri); // R8

    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        !(send && recv)); // R10

    AST_TI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ti_clr |=> (!ti || $fell(send))); // R11

endmodule

bind ssp_port ssp_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (ph_w),
    .send   (send_w),
    .recv   (recv_w),
    .ti     (ti),
    .ri     (ri),
    .ti_clr (ti_clr),
    .ri_clr (ri_clr),
    .sclk   (sclk)
);

// File: tb/ssp_port_test.sv
module ssp_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ren = 1'b0;
    logic       ti_clr = 1'b0;
    logic       ri_clr = 1'b0;
    logic       ti, ri;
    logic       sd_in = 1'b0;
    logic       sd_out, sd_oe, sclk;

    int checks = 0;
    int fails  = 0;
    int bph    = 0;

    always #2.5 clk = ~clk;

    ssp_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ren(ren), .ti_clr(ti_clr), .ri_clr(ri_clr),
        .ti(ti), .ri(ri), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
        .sclk(sclk)
    );

    // State tracker per R1: S1 after reset, one state per clock, wrap after S6.
    always @(posedge clk) begin
        if (!rst_n) bph <= 0;
        else        bph <= (bph == 5) ? 0 : bph + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_active(input int rel);
        return (rel / 6) >= 2 && (rel / 6) <= 9;
    endfunction

    function automatic bit exp_sclk(input int rel);
        return !(exp_active(rel) && (rel % 6) >= 2 && (rel % 6) <= 4);
    endfunction

    task automatic wait_ph(input int p);
        @(negedge clk);
        while (bph != p) @(negedge clk);
    endtask

    // Transmit from a write seen in state p0; optional extra write at step xoff.
    task automatic run_tx(input logic [7:0] d, input int p0, input int xoff);
        wait_ph(p0);
        wr_en = 1'b1; wr_data = d;
        for (int j = 1; p0 + j <= 66; j++) begin
            @(negedge clk);
            wr_en   = (j == xoff);
            wr_data = ~d;
            chk(sd_oe == exp_active(p0 + j), "R3 oe", sd_oe, exp_active(p0 + j));
            if (exp_active(p0 + j))
                chk(sd_out == d[(p0 + j) / 6 - 2], "R4 data", sd_out, d[(p0 + j) / 6 - 2]);
            chk(sclk == exp_sclk(p0 + j), "R2 sclk tx", sclk, exp_sclk(p0 + j));
            chk(ti == ((p0 + j) >= 60), "R5 ti", ti, (p0 + j) >= 60);
            if (xoff > 0 && j > xoff && (p0 + j) < 60)
                chk(sd_oe == exp_active(p0 + j), "R10 write ignored", sd_oe, exp_active(p0 + j));
        end
        wr_en = 1'b0;
        ti_clr = 1'b1;
        @(negedge clk);
        ti_clr = 1'b0;
        chk(ti == 1'b0, "R11 ti_clr", ti, 0);
    endtask

    // Receive started in state p0, either by raising ren or by clearing ri.
    task automatic run_rx(input logic [7:0] d, input int p0, input bit via_clr, input int xoff);
        int o;
        int rel;
        int cyc;
        bit b;
        o = via_clr ? p0 + 1 : p0;
        wait_ph(p0);
        if (via_clr) ri_clr = 1'b1;
        else         ren = 1'b1;
        rel = 0;
        for (int j = 1; rel < 62; j++) begin
            @(negedge clk);
            ri_clr = 1'b0;
            wr_en  = (j == xoff);
            wr_data = 8'hFF;
            rel = p0 + j - (o / 6) * 6;
            cyc = rel / 6;
            b = (cyc >= 2 && cyc <= 9) ? d[cyc - 2] : 1'b0;
            sd_in = (bph == 4) ? b : ~b;
            chk(sd_oe == 1'b0, "R6 oe idle", sd_oe, 0);
            chk(sclk == exp_sclk(rel), "R2 sclk rx", sclk, exp_sclk(rel));
            chk(ri == (rel >= 60), "R8 ri", ri, rel >= 60);
            if (j == 1 && via_clr)
                chk(ri == 1'b0, "R11 ri_clr", ri, 0);
            if (rel >= 60)
                chk(rd_data == d, "R7 byte", rd_data, d);
            if (xoff > 0 && j > xoff)
                chk(sd_oe == 1'b0, "R10 write ignored rx", sd_oe, 0);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1, "R1 sclk", sclk, 1);
        chk(sd_oe == 1'b0, "R1 oe", sd_oe, 0);
        chk(ti == 1'b0 && ri == 1'b0, "R1 flags", {ti, ri}, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        rst_n = 1'b1;

        // R9: no receive with ren low
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk(sclk == 1'b1 && ri == 1'b0, "R9 idle", {sclk, ri}, 2);
        end

        run_tx(8'hA5, 0, 0);
        run_tx(8'h01, 5, 20);
        run_tx(8'h80, 2, 40);
        for (int k = 0; k < 6; k++) run_tx(8'($urandom), int'($urandom % 6), 0);

        run_rx(8'h3C, 2, 1'b0, 0);
        // R8: ri held, no new receive while set
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(sclk == 1'b1 && ri == 1'b1, "R8 blocked", {sclk, ri}, 3);
            chk(rd_data == 8'h3C, "R8 buffer held", rd_data, 8'h3C);
        end
        run_rx(8'hC3, 5, 1'b1, 0);
        run_rx(8'h5A, 4, 1'b1, 25);
        for (int k = 0; k < 6; k++) run_rx(8'($urandom), int'($urandom % 6), 1'b1, 0);

        // transmit while ri is set and ren high
        run_tx(8'h96, 3, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule